// File: doc/BRIEF.md
# Byte-Wide SPI Master with Multi-Master Fault Detection

This block is a full-duplex SPI master. It sits behind a small register window with three addresses: control/status, data and clock divider. When software writes a byte to the data address while the master is enabled, the byte enters a transmit holding buffer. It moves into the shift register as soon as no transfer is running. The byte is then shifted out MSB-first on MOSI while the reply from the slave is shifted in from MISO. At the end of the eighth bit the received byte is copied into a receive buffer, which a read of the data address returns. A sticky completion flag marks the end of every transfer. It serves as both the transmit-done and the receive-ready indication, and it can raise an interrupt request.

A two-bit select-mode field sets how the slave-select pin behaves. In the shared-bus mode (the reset default) the pin is an input. When it is seen low, the master is shut down, a sticky fault flag is raised and any transfer in flight is abandoned. Software has to turn the master back on. In the 3-wire mode the pin is ignored and left undriven. In the 4-wire modes the pin becomes an output whose level software sets directly. The serial clock idles low, the slave samples on its rising edge, and its frequency is set by a programmable divider.

Top module: `spi_mst_mf`

## Requirements
- R1: After reset the control register (address 0) reads 0x04, meaning select mode 01 with every other bit 0. The divider register (address 2) reads DIV_RESET. SCK is low, `nss_oe` is 0 and `irq` is 0.
- R2: A transfer drives MOSI MSB-first. MOSI changes only after falling SCK edges and is stable at each rising edge. SCK idles low, and each SCK half period lasts divider+1 clock cycles.
- R3: The byte presented on MISO is captured MSB-first on the rising SCK edges. A read of the data register (address 1) after the transfer returns that byte.
- R4: The busy bit (control bit 5) is 1 while a transfer runs. The completion flag (control bit 7) is set when the eighth bit finishes.
- R5: The completion flag and the fault flag (control bit 6) are sticky. A control write with that bit 0 clears the flag; a write with that bit 1 leaves it unchanged.
- R6: `irq` is high exactly when the interrupt-enable bit (control bit 4) is 1 and the completion flag or the fault flag is set.
- R7: A data write is ignored unless both the SPI enable bit (control bit 0) and the master enable bit (control bit 1) are 1. The ignored byte is discarded and does not start a transfer later.
- R8: A data write made during a transfer is held in the transmit buffer. That byte is sent in a transfer that starts right after the current one ends.
- R9: In select mode 01 (control bits 3:2), while enabled, a low `nss_i` is seen after a two-flop synchronizer. It clears both enable bits, sets the fault flag and aborts the transfer. The master stays disabled after `nss_i` returns high, until software writes the enable bits again.
- R10: In select mode 00, `nss_i` has no effect and `nss_oe` is 0.
- R11: When control bit 3 is 1, `nss_oe` is 1 and `nss_o` equals control bit 2, with no fault detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control/status, 1 data, 2 divider |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational from `reg_addr`) |
| sck | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| nss_i | input | 1 | Slave-select pin input value |
| nss_o | output | 1 | Slave-select pin output value |
| nss_oe | output | 1 | Slave-select pin output enable |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle the bound checker confirms several properties. SCK is low whenever no transfer is active, and MOSI does not move at a rising SCK edge. A detected fault leaves both enables cleared and the fault flag set, and it has ended the transfer one cycle later. Both flags survive any cycle without a control write. The pin direction follows the select mode. The directed scenarios are what show the data values. These cover MSB-first serialization, the captured receive byte, the measured half-period length, the queued second byte following the first, the discarded write while disabled, and the master staying off after the select pin recovers.

// File: rtl/spi_mf_pkg.sv
package spi_mf_pkg;
   localparam logic [1:0] ADDR_CTRL = 2'd0;
   localparam logic [1:0] ADDR_DATA = 2'd1;
   localparam logic [1:0] ADDR_DIV  = 2'd2;

   localparam int CB_SPI_EN  = 0;
   localparam int CB_MST_EN  = 1;
   localparam int CB_MODE_LO = 2;
   localparam int CB_MODE_HI = 3;
   localparam int CB_IRQ_EN  = 4;
   localparam int CB_BUSY    = 5;
   localparam int CB_FAULT   = 6;
   localparam int CB_DONE    = 7;

   localparam logic [1:0] SEL_3WIRE = 2'b00;
   localparam logic [1:0] SEL_MULTI = 2'b01;
endpackage

// File: rtl/spi_mf_sync.sv
module spi_mf_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spi_mf_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], din};
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/spi_mf_engine.sv
module spi_mf_engine #(
   parameter int DATA_W = 8,
   parameter int DIV_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic [DIV_W-1:0]  div,
   input  logic              miso,
   output logic              sck,
   output logic              mosi,
   output logic              busy,
   output logic              done_pulse,
   output logic [DATA_W-1:0] rx_data
);
   localparam int BITC_W = $clog2(DATA_W + 1);
   localparam logic [BITC_W-1:0] LAST_BIT = BITC_W'(DATA_W - 1);

   logic [DIV_W-1:0]  half_cnt;
   logic [DATA_W-1:0] shreg;
   logic [BITC_W-1:0] bit_cnt;
   logic              rx_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         half_cnt   <= '0;
         shreg      <= '0;
         bit_cnt    <= '0;
         rx_bit     <= 1'b0;
         sck        <= 1'b0;
         busy       <= 1'b0;
         done_pulse <= 1'b0;
         rx_data    <= '0;
      end else begin
         done_pulse <= 1'b0;
         if (!run) begin
            busy     <= 1'b0;
            sck      <= 1'b0;
            half_cnt <= '0;
            bit_cnt  <= '0;
         end else if (load && !busy) begin
            shreg    <= load_data;
            busy     <= 1'b1;
            sck      <= 1'b0;
            half_cnt <= '0;
            bit_cnt  <= '0;
         end else if (busy) begin
            if (half_cnt == div) begin
               half_cnt <= '0;
               sck      <= ~sck;
               if (!sck) begin
                  rx_bit <= miso;
               end else begin
                  shreg   <= {shreg[DATA_W-2:0], rx_bit};
                  bit_cnt <= bit_cnt + 1'b1;
                  if (bit_cnt == LAST_BIT) begin
                     busy       <= 1'b0;
                     done_pulse <= 1'b1;
                     rx_data    <= {shreg[DATA_W-2:0], rx_bit};
                  end
               end
            end else begin
               half_cnt <= half_cnt + 1'b1;
            end
         end
      end
   end

   assign mosi = shreg[DATA_W-1];
endmodule

// File: rtl/spi_mf_regs.sv
module spi_mf_regs
   import spi_mf_pkg::*;
#(
   parameter int              DATA_W    = 8,
   parameter int              DIV_W     = 8,
   parameter logic [DIV_W-1:0] DIV_RESET = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              nss_sync,
   input  logic              busy,
   input  logic              done_pulse,
   input  logic [DATA_W-1:0] rx_data,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              run,
   output logic              load,
   output logic [DATA_W-1:0] tx_byte,
   output logic [DIV_W-1:0]  div,
   output logic [1:0]        mode,
   output logic              spi_en,
   output logic              mst_en,
   output logic              irq_en,
   output logic              fault_flag,
   output logic              done_flag,
   output logic              fault_evt,
   output logic              ctrl_wr
);
   logic tx_pend;
   logic data_wr;

   assign run       = spi_en && mst_en;
   assign ctrl_wr   = reg_wr && (reg_addr == ADDR_CTRL);
   assign data_wr   = reg_wr && (reg_addr == ADDR_DATA);
   assign fault_evt = run && (mode == SEL_MULTI) && !nss_sync;
   assign load      = run && tx_pend && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         spi_en     <= 1'b0;
         mst_en     <= 1'b0;
         mode       <= SEL_MULTI;
         irq_en     <= 1'b0;
         fault_flag <= 1'b0;
         done_flag  <= 1'b0;
         div        <= DIV_RESET;
         tx_byte    <= '0;
         tx_pend    <= 1'b0;
      end else begin
         if (ctrl_wr) begin
            spi_en     <= reg_wdata[CB_SPI_EN];
            mst_en     <= reg_wdata[CB_MST_EN];
            mode       <= reg_wdata[CB_MODE_HI:CB_MODE_LO];
            irq_en     <= reg_wdata[CB_IRQ_EN];
            fault_flag <= fault_flag && reg_wdata[CB_FAULT];
            done_flag  <= done_flag && reg_wdata[CB_DONE];
         end
         if (done_pulse) done_flag <= 1'b1;
         if (fault_evt) begin
            spi_en     <= 1'b0;
            mst_en     <= 1'b0;
            fault_flag <= 1'b1;
         end
         if (reg_wr && reg_addr == ADDR_DIV) div <= reg_wdata[DIV_W-1:0];
         if (!run) begin
            tx_pend <= 1'b0;
         end else if (data_wr) begin
            tx_byte <= reg_wdata;
            tx_pend <= 1'b1;
         end else if (load) begin
            tx_pend <= 1'b0;
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADDR_CTRL: begin
            reg_rdata[CB_SPI_EN]             = spi_en;
            reg_rdata[CB_MST_EN]             = mst_en;
            reg_rdata[CB_MODE_HI:CB_MODE_LO] = mode;
            reg_rdata[CB_IRQ_EN]             = irq_en;
            reg_rdata[CB_BUSY]               = busy;
            reg_rdata[CB_FAULT]              = fault_flag;
            reg_rdata[CB_DONE]               = done_flag;
         end
         ADDR_DATA: reg_rdata = rx_data;
         ADDR_DIV:  reg_rdata = DATA_W'(div);
         default:   reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/spi_mst_mf.sv
module spi_mst_mf
   import spi_mf_pkg::*;
#(
   parameter int              DATA_W      = 8,
   parameter int              DIV_W       = 8,
   parameter int              SYNC_STAGES = 2,
   parameter logic [DIV_W-1:0] DIV_RESET   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              sck,
   output logic              mosi,
   input  logic              miso,
   input  logic              nss_i,
   output logic              nss_o,
   output logic              nss_oe,
   output logic              irq
);
   generate
      if (DATA_W < 8) begin : g_bad_data_w
         $error("spi_mst_mf: DATA_W must be at least 8 to hold the control bits");
      end
      if (DIV_W < 1 || DIV_W > DATA_W) begin : g_bad_div_w
         $error("spi_mst_mf: DIV_W must be between 1 and DATA_W");
      end
   endgenerate

   logic              nss_sync;
   logic              run, load, busy, done_pulse;
   logic [DATA_W-1:0] tx_byte, rx_data;
   logic [DIV_W-1:0]  div;
   logic [1:0]        mode;
   logic              spi_en, mst_en, irq_en;
   logic              fault_flag, done_flag, fault_evt, ctrl_wr;

   spi_mf_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (nss_i),
      .dout (nss_sync)
   );

   spi_mf_regs #(.DATA_W(DATA_W), .DIV_W(DIV_W), .DIV_RESET(DIV_RESET)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .nss_sync  (nss_sync),
      .busy      (busy),
      .done_pulse(done_pulse),
      .rx_data   (rx_data),
      .reg_rdata (reg_rdata),
      .run       (run),
      .load      (load),
      .tx_byte   (tx_byte),
      .div       (div),
      .mode      (mode),
      .spi_en    (spi_en),
      .mst_en    (mst_en),
      .irq_en    (irq_en),
      .fault_flag(fault_flag),
      .done_flag (done_flag),
      .fault_evt (fault_evt),
      .ctrl_wr   (ctrl_wr)
   );

   spi_mf_engine #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .load      (load),
      .load_data (tx_byte),
      .div       (div),
      .miso      (miso),
      .sck       (sck),
      .mosi      (mosi),
      .busy      (busy),
      .done_pulse(done_pulse),
      .rx_data   (rx_data)
   );

   assign nss_oe = mode[1];
   assign nss_o  = mode[1] ? mode[0] : 1'b1;
   assign irq    = irq_en && (done_flag || fault_flag);
endmodule

// File: rtl/spi_mf_chk.sv
module spi_mf_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       sck,
   input logic       mosi,
   input logic       nss_o,
   input logic       nss_oe,
   input logic       irq,
   input logic       busy,
   input logic [1:0] mode,
   input logic       spi_en,
   input logic       mst_en,
   input logic       irq_en,
   input logic       fault_flag,
   input logic       done_flag,
   input logic       fault_evt,
   input logic       ctrl_wr
);
   assert_sck_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sck);

   assert_mosi_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sck) |-> $stable(mosi));

   assert_done_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done_flag && !ctrl_wr) |=> done_flag);

   assert_fault_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_flag && !ctrl_wr) |=> fault_flag);

   assert_irq_on_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(done_flag) && irq_en) |-> irq);

   assert_fault_disables_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fault_evt |=> (!spi_en && !mst_en && fault_flag));

   assert_fault_aborts_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fault_evt |=> ##1 (!busy && !sck));

   assert_no_drive_3wire_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b00) |-> !nss_oe);

   assert_nss_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
      mode[1] |-> (nss_oe && nss_o == mode[0]));
endmodule

bind spi_mst_mf spi_mf_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sck       (sck),
   .mosi      (mosi),
   .nss_o     (nss_o),
   .nss_oe    (nss_oe),
   .irq       (irq),
   .busy      (busy),
   .mode      (mode),
   .spi_en    (spi_en),
   .mst_en    (mst_en),
   .irq_en    (irq_en),
   .fault_flag(fault_flag),
   .done_flag (done_flag),
   .fault_evt (fault_evt),
   .ctrl_wr   (ctrl_wr)
);

// File: tb/tb_spi_mst_mf.sv
module tb_spi_mst_mf;
   localparam time CLK_PERIOD = 10ns;
   localparam int  DATA_W     = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reg_wr = 1'b0;
   logic [1:0]        reg_addr = 2'd0;
   logic [DATA_W-1:0] reg_wdata = '0;
   logic [DATA_W-1:0] reg_rdata;
   logic              sck, mosi, nss_o, nss_oe, irq;
   logic              miso = 1'b0;
   logic              nss_i = 1'b1;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   spi_mst_mf dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck(sck), .mosi(mosi),
      .miso(miso), .nss_i(nss_i), .nss_o(nss_o), .nss_oe(nss_oe), .irq(irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic wait_done(output bit seen);
      logic [7:0] v;
      seen = 0;
      for (int i = 0; i < 2000; i++) begin
         rd(2'd0, v);
         if (v[7]) begin seen = 1; break; end
      end
   endtask

   task automatic slave_run(input int nbits, input logic [15:0] sdata, output logic [15:0] cap);
      cap  = '0;
      miso = sdata[nbits-1];
      for (int i = nbits - 1; i >= 0; i--) begin
         @(posedge sck);
         cap[i] = mosi;
         @(negedge sck);
         if (i > 0) miso = sdata[i-1];
      end
   endtask

   task automatic t_reset;
      logic [7:0] v;
      rd(2'd0, v); check(v == 8'h04, "R1 ctrl reset", v, 8'h04);
      rd(2'd2, v); check(v == 8'h03, "R1 div reset", v, 8'h03);
      check({sck, nss_oe, irq} == 3'b000, "R1 pins reset", {sck, nss_oe, irq}, 0);
   endtask

   task automatic t_disabled;
      logic [7:0] v;
      bit moved = 0;
      wr(2'd1, 8'h99);
      for (int i = 0; i < 40; i++) begin @(negedge clk); if (sck) moved = 1; end
      rd(2'd0, v); check(v == 8'h04 && !moved, "R7 write ignored while disabled", v, 8'h04);
      wr(2'd0, 8'h17);
      for (int i = 0; i < 40; i++) begin @(negedge clk); if (sck) moved = 1; end
      rd(2'd0, v); check(v == 8'h17 && !moved, "R7 discarded byte not sent later", v, 8'h17);
   endtask

   task automatic t_basic;
      logic [15:0] cap;
      logic [7:0]  v;
      int hi = 0;
      bit seen;
      wr(2'd2, 8'h01);
      fork
         slave_run(8, 16'h003C, cap);
         begin
            @(posedge sck);
            do begin @(negedge clk); if (sck) hi++; end while (sck);
         end
         begin
            wr(2'd1, 8'hA5);
            repeat (3) @(negedge clk);
            rd(2'd0, v); check(v[5] == 1'b1, "R4 busy during transfer", v, 8'h20);
         end
      join
      wait_done(seen);
      check(seen, "R4 completion flag set", seen, 1);
      check(cap[7:0] == 8'hA5, "R2 MOSI MSB-first", cap[7:0], 8'hA5);
      check(hi == 2, "R2 half period = div+1", hi, 2);
      rd(2'd1, v); check(v == 8'h3C, "R3 received byte", v, 8'h3C);
      rd(2'd0, v); check(v == 8'h97, "R4 busy low after end", v, 8'h97);
      check(irq == 1'b1, "R6 irq on completion", irq, 1);
   endtask

   task automatic t_sticky;
      logic [7:0] v;
      wr(2'd0, 8'h97);
      rd(2'd0, v); check(v[7] == 1'b1, "R5 write 1 keeps flag", v, 8'h97);
      wr(2'd0, 8'h17);
      rd(2'd0, v); check(v == 8'h17, "R5 write 0 clears flag", v, 8'h17);
      check(irq == 1'b0, "R6 irq low with flags clear", irq, 0);
   endtask

   task automatic t_queue;
      logic [15:0] cap;
      logic [7:0]  v;
      bit seen;
      wr(2'd2, 8'h00);
      fork
         slave_run(16, 16'hC35A, cap);
         begin
            wr(2'd1, 8'h81);
            repeat (4) @(negedge clk);
            wr(2'd1, 8'h7E);
         end
      join
      repeat (3) @(negedge clk);
      check(cap == 16'h817E, "R8 queued byte follows", cap, 16'h817E);
      rd(2'd1, v); check(v == 8'h5A, "R8 second received byte", v, 8'h5A);
      wait_done(seen);
      rd(2'd0, v); check(v[5] == 1'b0 && seen, "R8 idle after both", v, 8'h97);
      wr(2'd0, 8'h17);
   endtask

   task automatic t_fault;
      logic [7:0] v;
      bit moved = 0;
      wr(2'd2, 8'h03);
      wr(2'd1, 8'hFF);
      repeat (12) @(negedge clk);
      nss_i = 1'b0;
      repeat (6) @(negedge clk);
      rd(2'd0, v); check(v == 8'h54, "R9 fault disables master", v, 8'h54);
      check(sck == 1'b0 && irq == 1'b1, "R9 abort and irq", {sck, irq}, 1);
      nss_i = 1'b1;
      repeat (5) @(negedge clk);
      wr(2'd1, 8'h55);
      for (int i = 0; i < 30; i++) begin @(negedge clk); if (sck) moved = 1; end
      rd(2'd0, v); check(v == 8'h54 && !moved, "R9 stays disabled", v, 8'h54);
      wr(2'd0, 8'h17);
      rd(2'd0, v); check(v == 8'h17 && !irq, "R9 re-enable clears fault", v, 8'h17);
   endtask

   task automatic t_3wire;
      logic [15:0] cap;
      logic [7:0]  v;
      bit seen;
      wr(2'd0, 8'h13);
      nss_i = 1'b0;
      repeat (4) @(negedge clk);
      check(nss_oe == 1'b0, "R10 pin not driven", nss_oe, 0);
      fork
         slave_run(8, 16'h005A, cap);
         wr(2'd1, 8'hC3);
      join
      wait_done(seen);
      rd(2'd0, v); check(v == 8'h93 && seen, "R10 NSS low ignored", v, 8'h93);
      rd(2'd1, v); check(v == 8'h5A && cap[7:0] == 8'hC3, "R10 transfer completes", v, 8'h5A);
      wr(2'd0, 8'h13);
   endtask

   task automatic t_4wire;
      logic [7:0] v;
      wr(2'd0, 8'h0B);
      @(negedge clk);
      check(nss_oe == 1'b1 && nss_o == 1'b0, "R11 drive low", {nss_oe, nss_o}, 2);
      wr(2'd0, 8'h0F);
      repeat (4) @(negedge clk);
      check(nss_oe == 1'b1 && nss_o == 1'b1, "R11 drive high", {nss_oe, nss_o}, 3);
      rd(2'd0, v); check(v == 8'h0F, "R11 no fault with NSS low", v, 8'h0F);
      nss_i = 1'b1;
   endtask

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_disabled();
      t_basic();
      t_sticky();
      t_queue();
      t_fault();
      t_3wire();
      t_4wire();
      finished = 1;
      summary();
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         summary();
      end
   end
endmodule